// File: doc/BRIEF.md
# Posted Write Queue with Uncached Ordering Barrier

This block sits between a requester and system memory and posts cacheable writes. A write is taken into a FIFO the moment it is offered, and the requester does not wait for memory. Entries leave the FIFO for the memory write port on their own. They leave in arrival order, one per cycle while memory is ready, and no later traffic or flush command is needed to push them out. Each entry carries a one-bit class tag (asynchronous or isochronous). Both classes drain the same way.

An uncached access is an I/O read or write, or a flag write that tells a consumer data is ready. The block treats such an access as an ordering barrier. When it is accepted, the block counts the writes posted before it. The access is only forwarded on the uncached target port once all of those writes have been handed to memory.

Writes that arrive after the barrier are still accepted. They stay in the queue until the target port has taken the uncached access. After the target acknowledges, the response goes back to the requester, and the block accepts only one uncached access at a time. A head-age counter raises an urgency flag on the memory port when the oldest entry has waited too long.

Top module: `pwq_top`

## Requirements
- R1: After reset the block drives wrReady=1, ucReady=1, memValid=0, tgtValid=0, ucRespValid=0 and memUrgent=0.
- R2: wrReady is high whenever fewer than DEPTH entries are held. A write offered with wrValid=1 in such a cycle is taken at that clock edge, whatever the state of memReady.
- R3: Queued writes appear on memAddr/memData in exactly the order they were accepted, and one entry leaves per edge where memValid and memReady are both 1. While memValid=1 and memReady=0, memValid and the payload stay unchanged.
- R4: A write accepted into an empty queue raises memValid in the next cycle with no other input activity.
- R5: The class bit wrIsoc (0 = asynchronous, 1 = isochronous) comes out unchanged on memIsoc with its entry, and both classes drain the same way.
- R6: With DEPTH entries held, wrReady is 0, and a write offered then is dropped: it never appears on the memory port.
- R7: ucReady is 0 from the edge that accepts an uncached request until the edge where the target acknowledges it. An uncached request offered during that time is ignored.
- R8: tgtValid stays 0 until every write accepted before the uncached request has been handed to memory. A write accepted at the same edge as the uncached request counts as earlier. With an empty queue, tgtValid rises in the cycle after acceptance.
- R9: Writes accepted after the uncached request are held (memValid=0) from the moment the older writes are gone until the target handshake. They resume draining in the cycle after that handshake.
- R10: While tgtValid=1, the block presents tgtIsWrite/tgtAddr/tgtWdata equal to the captured ucIsWrite/ucAddr/ucWdata. ucRespValid is a one-cycle pulse in the cycle after tgtValid&&tgtReady, and ucRespData then equals the tgtRdata sampled at that handshake.
- R11: memUrgent rises once the head entry has sat AGE_LIMIT edges without leaving. It is 0 in the cycle after any entry leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Posted write offered |
| wrReady | output | 1 | Posted write can be taken |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| wrIsoc | input | 1 | Write class, 1 = isochronous |
| ucValid | input | 1 | Uncached request offered |
| ucReady | output | 1 | Uncached request can be taken |
| ucIsWrite | input | 1 | Uncached request is a write |
| ucAddr | input | ADDR_W | Uncached address |
| ucWdata | input | DATA_W | Uncached write data |
| ucRespValid | output | 1 | Uncached completion pulse |
| ucRespData | output | DATA_W | Uncached read return data |
| memValid | output | 1 | Memory write presented |
| memReady | input | 1 | Memory takes the write |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| memIsoc | output | 1 | Memory write class |
| memUrgent | output | 1 | Head entry has aged past the limit |
| tgtValid | output | 1 | Uncached access forwarded |
| tgtReady | input | 1 | Target acknowledges the access |
| tgtIsWrite | output | 1 | Forwarded access is a write |
| tgtAddr | output | ADDR_W | Forwarded address |
| tgtWdata | output | DATA_W | Forwarded write data |
| tgtRdata | input | DATA_W | Target read data, sampled at acknowledge |

## Verification
The assertions check the cycle-level rules on every cycle:
- the memory payload holds under back-pressure;
- the memory port is gated while the target request is up;
- only one uncached access is outstanding;
- a same-edge write always delays forwarding;
- the completion pulse follows the acknowledge;
- the urgency flag clears after a drain.

Only the bench scenarios can show the rest. These cover arrival order across a stall, class tags surviving the queue, and a write dropped at full depth. They also check that the exact older set drains before forwarding while a younger write waits, and the exact edge where the age flag rises.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  typedef struct packed {
    logic push;      // take the offered posted write
    logic pop;       // hand the head entry to memory
    logic ucLoad;    // capture an uncached request
    logic respLoad;  // capture target return data
  } pwqStrobe_t;
endpackage

// File: rtl/pwq_datapath.sv
module pwq_datapath
  import pwq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int AGE_LIMIT = 16,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrIsoc,
  input  logic              ucIsWrite,
  input  logic [ADDR_W-1:0] ucAddr,
  input  logic [DATA_W-1:0] ucWdata,
  input  logic [DATA_W-1:0] tgtRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memIsoc,
  output logic              memUrgent,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              tgtIsWrite,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtWdata,
  output logic [DATA_W-1:0] ucRespData
);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic              entIsoc [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [AGE_W-1:0]  headAge;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(e)) begin
        entAddr[e] <= wrAddr;
        entData[e] <= wrData;
        entIsoc[e] <= wrIsoc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      fifoCount <= fifoCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  // age of the current head entry, restarted whenever the head changes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headAge <= '0;
    end else if (strobe.pop || fifoEmpty) begin
      headAge <= '0;
    end else if (headAge != AGE_W'(AGE_LIMIT)) begin
      headAge <= headAge + AGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtIsWrite <= 1'b0;
      tgtAddr    <= '0;
      tgtWdata   <= '0;
      ucRespData <= '0;
    end else begin
      if (strobe.ucLoad) begin
        tgtIsWrite <= ucIsWrite;
        tgtAddr    <= ucAddr;
        tgtWdata   <= ucWdata;
      end
      if (strobe.respLoad) ucRespData <= tgtRdata;
    end
  end

  assign fifoEmpty = (fifoCount == '0);
  assign fifoFull  = (fifoCount == CNT_W'(DEPTH));
  assign memAddr   = entAddr[rdPtr];
  assign memData   = entData[rdPtr];
  assign memIsoc   = entIsoc[rdPtr];
  assign memUrgent = (headAge == AGE_W'(AGE_LIMIT));

endmodule

// File: rtl/pwq_control.sv
module pwq_control
  import pwq_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             ucValid,
  input  logic             memReady,
  input  logic             tgtReady,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  output logic             wrReady,
  output logic             ucReady,
  output logic             memValid,
  output logic             tgtValid,
  output logic             ucRespValid,
  output logic             ucBusy,
  output logic [CNT_W-1:0] barCnt,
  output pwqStrobe_t       strobe
);

  logic [CNT_W-1:0] countNext;
  logic             tgtFire;

  assign wrReady  = !fifoFull;
  assign ucReady  = !ucBusy;
  // forwarding opens once no older write remains
  assign tgtValid = ucBusy && (barCnt == '0);
  // younger writes wait while the barrier is being forwarded
  assign memValid = !fifoEmpty && !tgtValid;
  assign tgtFire  = tgtValid && tgtReady;

  always_comb begin
    strobe          = '0;
    strobe.push     = wrValid && wrReady;
    strobe.pop      = memValid && memReady;
    strobe.ucLoad   = ucValid && ucReady;
    strobe.respLoad = tgtFire;
  end

  // same-edge write counts as older than the barrier
  assign countNext = fifoCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ucBusy      <= 1'b0;
      barCnt      <= '0;
      ucRespValid <= 1'b0;
    end else begin
      ucRespValid <= tgtFire;
      if (strobe.ucLoad) begin
        ucBusy <= 1'b1;
        barCnt <= countNext;
      end else begin
        if (tgtFire) ucBusy <= 1'b0;
        if (ucBusy && strobe.pop && barCnt != '0) barCnt <= barCnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pwq_top.sv
module pwq_top
  import pwq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int AGE_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrIsoc,
  input  logic              ucValid,
  output logic              ucReady,
  input  logic              ucIsWrite,
  input  logic [ADDR_W-1:0] ucAddr,
  input  logic [DATA_W-1:0] ucWdata,
  output logic              ucRespValid,
  output logic [DATA_W-1:0] ucRespData,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memIsoc,
  output logic              memUrgent,
  output logic              tgtValid,
  input  logic              tgtReady,
  output logic              tgtIsWrite,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [DATA_W-1:0] tgtWdata,
  input  logic [DATA_W-1:0] tgtRdata
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  pwqStrobe_t       strobe;
  logic [CNT_W-1:0] fifoCount;
  logic [CNT_W-1:0] barCnt;
  logic             fifoEmpty, fifoFull, ucBusy;

  pwq_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .ucValid(ucValid),
    .memReady(memReady), .tgtReady(tgtReady), .fifoCount(fifoCount),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .wrReady(wrReady),
    .ucReady(ucReady), .memValid(memValid), .tgtValid(tgtValid),
    .ucRespValid(ucRespValid), .ucBusy(ucBusy), .barCnt(barCnt),
    .strobe(strobe)
  );

  pwq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .wrIsoc(wrIsoc), .ucIsWrite(ucIsWrite),
    .ucAddr(ucAddr), .ucWdata(ucWdata), .tgtRdata(tgtRdata),
    .memAddr(memAddr), .memData(memData), .memIsoc(memIsoc),
    .memUrgent(memUrgent), .fifoCount(fifoCount), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .tgtIsWrite(tgtIsWrite), .tgtAddr(tgtAddr),
    .tgtWdata(tgtWdata), .ucRespData(ucRespData)
  );

endmodule

// File: rtl/pwq_checker.sv
module pwq_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrReady,
  input logic              ucValid,
  input logic              ucReady,
  input logic              ucRespValid,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              memUrgent,
  input logic              tgtValid,
  input logic              tgtReady,
  input logic [CNT_W-1:0]  fifoCount
);

  // R2
  accept_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount < CNT_W'(DEPTH)) |-> wrReady);

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !wrReady);

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ucValid && ucReady) |=> !ucReady);

  // R8
  same_edge_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ucValid && ucReady && wrValid && wrReady) |=> !tgtValid);

  // R9
  barrier_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> !memValid);

  // R10
  resp_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && tgtReady) |=> ucRespValid);

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ucRespValid |=> !ucRespValid);

  // R11
  urgent_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> !memUrgent);

endmodule

bind pwq_top pwq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .ucValid(ucValid), .ucReady(ucReady), .ucRespValid(ucRespValid),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
  .memData(memData), .memUrgent(memUrgent), .tgtValid(tgtValid),
  .tgtReady(tgtReady), .fifoCount(fifoCount)
);

// File: tb/pwq_top_tb_top.sv
`timescale 1ns/100ps
module pwq_top_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int AGE_LIMIT = 16;
  localparam int NVEC = 6;

  // {stall, isoc, addr, data}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 16'h1000, 32'hA000_0001},
    {1'b0, 1'b1, 16'h1004, 32'hA000_0002},
    {1'b1, 1'b0, 16'h2008, 32'hB0B0_0003},
    {1'b0, 1'b1, 16'h300C, 32'hC0C0_0004},
    {1'b1, 1'b1, 16'h4010, 32'hD0D0_0005},
    {1'b0, 1'b0, 16'hFFFC, 32'hFFFF_0006}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, wrIsoc = 0, ucValid = 0, ucIsWrite = 0, memReady = 0, tgtReady = 0;
  logic [ADDR_W-1:0] wrAddr = '0, ucAddr = '0;
  logic [DATA_W-1:0] wrData = '0, ucWdata = '0, tgtRdata = '0;
  logic wrReady, ucReady, ucRespValid, memValid, memIsoc, memUrgent, tgtValid, tgtIsWrite;
  logic [DATA_W-1:0] ucRespData, memData, tgtWdata;
  logic [ADDR_W-1:0] memAddr, tgtAddr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrIsoc(wrIsoc), .ucValid(ucValid), .ucReady(ucReady),
    .ucIsWrite(ucIsWrite), .ucAddr(ucAddr), .ucWdata(ucWdata),
    .ucRespValid(ucRespValid), .ucRespData(ucRespData), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData), .memIsoc(memIsoc),
    .memUrgent(memUrgent), .tgtValid(tgtValid), .tgtReady(tgtReady),
    .tgtIsWrite(tgtIsWrite), .tgtAddr(tgtAddr), .tgtWdata(tgtWdata),
    .tgtRdata(tgtRdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic c);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrIsoc = c;
    tick();
    wrValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [ADDR_W-1:0] held;
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 wrReady", 64'(wrReady), 64'd1);
    chk("R1 ucReady", 64'(ucReady), 64'd1);
    chk("R1 memValid", 64'(memValid), 64'd0);
    chk("R1 tgtValid", 64'(tgtValid), 64'd0);
    chk("R1 ucRespValid", 64'(ucRespValid), 64'd0);
    chk("R1 memUrgent", 64'(memUrgent), 64'd0);

    // table walk: fill with memory stalled, then drain with stalls
    memReady = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      wrValid = 1'b1; wrIsoc = VEC[i][48]; wrAddr = VEC[i][47:32]; wrData = VEC[i][31:0];
      #1 chk("R2 wrReady while room", 64'(wrReady), 64'd1);
      tick();
    end
    wrValid = 1'b0;
    #1 chk("R4 memValid without other traffic", 64'(memValid), 64'd1);
    memReady = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][49]) begin
        memReady = 1'b0;
        #1 held = memAddr;
        tick();
        chk("R3 payload held under stall", 64'(memAddr), 64'(held));
        memReady = 1'b1;
      end
      #1;
      chk("R3 memValid", 64'(memValid), 64'd1);
      chk("R3 order addr", 64'(memAddr), 64'(VEC[i][47:32]));
      chk("R3 order data", 64'(memData), 64'(VEC[i][31:0]));
      chk("R5 class tag", 64'(memIsoc), 64'(VEC[i][48]));
      tick();
    end
    #1 chk("R3 queue empty after drain", 64'(memValid), 64'd0);

    // full depth and dropped write
    memReady = 1'b0;
    for (int i = 0; i < DEPTH; i++) pushWr(16'h0100 + 16'(i), 32'h5500_0000 + 32'(i), 1'b0);
    #1 chk("R6 wrReady low when full", 64'(wrReady), 64'd0);
    pushWr(16'hDEAD, 32'hDEAD_DEAD, 1'b1);
    memReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1 chk("R6 full drain order", 64'(memAddr), 64'(16'h0100 + 16'(i)));
      tick();
    end
    #1 chk("R6 dropped write absent", 64'(memValid), 64'd0);

    // age flag
    memReady = 1'b0;
    pushWr(16'h0ABC, 32'h1234_5678, 1'b1);
    repeat (AGE_LIMIT - 1) tick();
    #1 chk("R11 not urgent before limit", 64'(memUrgent), 64'd0);
    tick();
    #1 chk("R11 urgent at limit", 64'(memUrgent), 64'd1);
    memReady = 1'b1;
    tick();
    memReady = 1'b0;
    #1 chk("R11 urgent clears after drain", 64'(memUrgent), 64'd0);

    // barrier with older, same-edge and younger writes
    for (int i = 0; i < 3; i++) pushWr(16'h0C00 + 16'(i), 32'(i), 1'b0);
    wrValid = 1'b1; wrAddr = 16'h0C03; wrData = 32'd3; wrIsoc = 1'b1;
    ucValid = 1'b1; ucIsWrite = 1'b1; ucAddr = 16'h0F1A; ucWdata = 32'h0000_F1A6;
    #1 chk("R7 ucReady when idle", 64'(ucReady), 64'd1);
    tick();
    ucValid = 1'b0;
    wrAddr = 16'h0C04; wrData = 32'd4; wrIsoc = 1'b0;
    #1 chk("R8 no forward with older writes", 64'(tgtValid), 64'd0);
    tick();
    wrValid = 1'b0;
    ucValid = 1'b1; ucAddr = 16'h0BAD; ucIsWrite = 1'b0;
    #1 chk("R7 second uncached blocked", 64'(ucReady), 64'd0);
    for (int i = 0; i < 3; i++) begin
      #1 chk("R8 hold while memory stalled", 64'(tgtValid), 64'd0);
      tick();
    end
    ucValid = 1'b0;
    memReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R8 older write drains first", 64'(memAddr), 64'(16'h0C00 + 16'(i)));
      chk("R8 no forward during drain", 64'(tgtValid), 64'd0);
      tick();
    end
    #1;
    chk("R8 forward after older drained", 64'(tgtValid), 64'd1);
    chk("R9 younger write held", 64'(memValid), 64'd0);
    chk("R10 tgtAddr", 64'(tgtAddr), 64'h0F1A);
    chk("R10 tgtIsWrite", 64'(tgtIsWrite), 64'd1);
    chk("R10 tgtWdata", 64'(tgtWdata), 64'h0000_F1A6);
    tick();
    #1 chk("R9 younger still held", 64'(memValid), 64'd0);
    tgtReady = 1'b1; tgtRdata = 32'hCAFE_0001;
    tick();
    tgtReady = 1'b0;
    #1;
    chk("R10 response pulse", 64'(ucRespValid), 64'd1);
    chk("R10 response data", 64'(ucRespData), 64'hCAFE_0001);
    chk("R7 ignored request not forwarded", 64'(tgtValid), 64'd0);
    chk("R9 younger resumes", 64'(memValid), 64'd1);
    chk("R9 younger addr", 64'(memAddr), 64'h0C04);
    tick();
    #1;
    chk("R10 pulse is one cycle", 64'(ucRespValid), 64'd0);
    chk("R7 ucReady after completion", 64'(ucReady), 64'd1);

    // barrier with empty queue
    ucValid = 1'b1; ucIsWrite = 1'b0; ucAddr = 16'h0200;
    tick();
    ucValid = 1'b0;
    #1;
    chk("R8 immediate forward when empty", 64'(tgtValid), 64'd1);
    chk("R10 read forwarded", 64'(tgtIsWrite), 64'd0);
    tgtReady = 1'b1; tgtRdata = 32'h5A5A_A5A5;
    tick();
    tgtReady = 1'b0;
    #1 chk("R10 read data returned", 64'(ucRespData), 64'h5A5A_A5A5);

    finish();
  end

endmodule